// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date in eight byte-wide registers coded in BCD. The registers hold, from lowest to highest index, hundredths of a second, seconds, minutes, hours, day of week, date, month and year. A one-cycle pulse on `tick_i`, arriving at 100 Hz, advances the chain. Each field carries into the next one when it wraps. The date wrap follows the length of the current month, and February follows the leap-year rule.

The hours register works in one of two formats, picked by its own top bit. In 24-hour format, bit 5 is the tens digit for the hours 20 to 23. In 12-hour format, bit 5 is a PM flag. Two spare bits of the day-of-week register are control bits. One stops the counting. The other decides whether an external active-low reset line may abort a serial transfer in progress.

A serial access engine sitting outside this block sees all 64 bits at once through `regs_o`. It replaces all of them in one cycle with `load_i` and `load_data_i`.

Top module: `bcd_timekeeper`

## Requirements
- R1: While reset is held and after it is released, the register image is hundredths 00, seconds 00, minutes 00, hours 00 in 24-hour format, day register 0x31 (stop bit and reset-ignore bit both 1, day 1), date 01, month 01 and year 00.
- R2: Hundredths count 00 to 99, and seconds and minutes count 00 to 59. Each of them returns to 00 after its last value and advances the next field up by one in the same tick.
- R3: Hours bit 7 at 0 selects 24-hour format. Hours then run 00 to 23, with bit 5 as the 20s digit and bit 4 as the 10s digit. A tick at 23:59:59.99 gives 00:00:00.00 and advances the day of week and the date.
- R4: Hours bit 7 at 1 selects 12-hour format. Bits 4:0 hold 12, 01 to 11 in BCD, and bit 5 is 1 for PM. The flag inverts when 11 rolls to 12, and 12 rolls to 01. The day and date advance only on the step from 11 PM to 12 AM.
- R5: The date (register 5, bits 5:0) returns to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months apart from February. On that step the month advances.
- R6: February ends at 29 when the BCD year is divisible by four (00, 04, …, 96) and at 28 otherwise.
- R7: Month 12 rolls to 01 and advances the year. Year 99 rolls to 00. The day of week (register 4, bits 2:0) counts 1 to 7 and then returns to 1.
- R8: While day-register bit 5 is 1, ticks change no register.
- R9: `xfer_abort_o` is 1 exactly when day-register bit 4 is 0 and `ext_rst_n_i` is low. With bit 4 at 1, the reset input has no effect on it.
- R10: Bits that are unused always read 0, whatever is loaded: seconds and minutes bit 7, hours bit 6, day bits 7:6 and 3, date bits 7:6, month bits 7:5.
- R11: A load in the same cycle as a tick stores exactly the loaded value (with unused bits cleared), and the tick is dropped.
- R12: A tick shows on `regs_o` after the first rising clock edge that samples it. Without a tick, the registers hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle 100 Hz advance pulse |
| load_i | input | 1 | Parallel load strobe for all eight registers |
| load_data_i | input | 64 | Load image, register n in bits 8n+7:8n |
| ext_rst_n_i | input | 1 | External active-low transfer reset line |
| regs_o | output | 64 | Register image, register n in bits 8n+7:8n |
| osc_off_o | output | 1 | Stop bit (day register bit 5) |
| rst_ignore_o | output | 1 | Reset-ignore bit (day register bit 4) |
| xfer_abort_o | output | 1 | Transfer abort request to the serial engine |

## Verification
Every register result, whether from a load or from a tick, is due on the first rising edge after the input is driven. The bench drives inputs on falling edges and checks `regs_o` on the next falling edge, which is exactly one edge later. `xfer_abort_o` is combinational, so it is checked on the same falling edge that changes `ext_rst_n_i`, after a short settle. Internal reset release takes two edges, and the bench waits three before it applies any stimulus.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int REG_W  = 8;
  localparam int N_REGS = 8;
  localparam int IMG_W  = REG_W * N_REGS;

  typedef logic [REG_W-1:0] reg_t;

  // bits that exist in each register; others read zero
  localparam logic [IMG_W-1:0] LIVE_MASK = 64'hFF1F_3F37_BF7F_7FFF;
  localparam logic [IMG_W-1:0] RST_IMAGE = 64'h0001_0131_0000_0000;

  function automatic reg_t bcd_inc(input reg_t v);
    reg_t r;
    logic [3:0] hi;
    hi = v[7:4] + 4'd1;
    if (v[3:0] >= 4'd9) r = {hi, 4'd0};
    else                r = v + 8'd1;
    return r;
  endfunction

  function automatic logic leap_year(input reg_t yr);
    logic [3:0] lo;
    lo = yr[3:0];
    if (yr[4]) return (lo == 4'd2) || (lo == 4'd6);
    else       return (lo == 4'd0) || (lo == 4'd4) || (lo == 4'd8);
  endfunction

  function automatic reg_t last_date(input reg_t mon, input reg_t yr);
    reg_t r;
    case (mon)
      8'h02:                      r = leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tk_bcd_ring.sv
module tk_bcd_ring
  import tk_pkg::*;
#(
  parameter reg_t LIMIT   = 8'h59,
  parameter reg_t FIRST   = 8'h00,
  parameter reg_t RST_VAL = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  reg_t load_val_i,
  input  logic step_i,
  output reg_t val_o,
  output logic wrap_o
);
  reg_t val_q, val_d;
  logic at_lim, en;

  assign at_lim = (val_q >= LIMIT);
  assign wrap_o = step_i & at_lim;
  assign en     = load_i | step_i;

  always_comb begin
    val_d = val_q;
    if (load_i)      val_d = load_val_i;
    else if (step_i) val_d = at_lim ? FIRST : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= RST_VAL;
    else if (en) val_q <= val_d;
  end

  assign val_o = val_q;

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && val_q == LIMIT) |=> (val_q == FIRST)); // R2

  AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(val_q)); // R12
endmodule

// File: rtl/tk_hours.sv
module tk_hours
  import tk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  reg_t load_val_i,
  input  logic step_i,
  output reg_t hr_o,
  output logic day_step_o
);
  reg_t hr_q, hr_d, inc12, inc24;
  logic mode12, pm, day_wrap, en;

  assign mode12 = hr_q[7];
  assign pm     = hr_q[5];
  assign inc12  = bcd_inc({3'b000, hr_q[4:0]});
  assign inc24  = bcd_inc({2'b00, hr_q[5:0]});
  assign en     = load_i | step_i;

  always_comb begin
    day_wrap = 1'b0;
    if (mode12) begin
      if (hr_q[4:0] == 5'h11) begin
        hr_d     = {2'b10, ~pm, 5'h12};
        day_wrap = pm;
      end else if (hr_q[4:0] >= 5'h12) begin
        hr_d = {2'b10, pm, 5'h01};
      end else begin
        hr_d = {2'b10, pm, inc12[4:0]};
      end
    end else begin
      if (hr_q[5:0] >= 6'h23) begin
        hr_d     = 8'h00;
        day_wrap = 1'b1;
      end else begin
        hr_d = {2'b00, inc24[5:0]};
      end
    end
    if (load_i) hr_d = load_val_i;
  end

  assign day_step_o = step_i & day_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hr_q <= 8'h00;
    else if (en) hr_q <= hr_d;
  end

  assign hr_o = hr_q;

  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && hr_q[7] && hr_q[4:0] == 5'h11) |=> (hr_q[5] != $past(hr_q[5]))); // R4

  AST_DAY24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !hr_q[7] && hr_q[5:0] == 6'h23) |=> (hr_q == 8'h00)); // R3
endmodule

// File: rtl/tk_weekday.sv
module tk_weekday
  import tk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  reg_t load_val_i,
  input  logic step_i,
  output reg_t day_o
);
  reg_t day_q, day_d;
  logic [2:0] dow_nx;
  logic en;

  assign dow_nx = (day_q[2:0] >= 3'd7 || day_q[2:0] == 3'd0) ? 3'd1 : day_q[2:0] + 3'd1;
  assign en     = load_i | step_i;

  always_comb begin
    if (load_i) day_d = load_val_i;
    else        day_d = {2'b00, day_q[5:4], 1'b0, dow_nx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  day_q <= 8'h31;
    else if (en) day_q <= day_d;
  end

  assign day_o = day_q;

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && day_q[2:0] == 3'd7) |=> (day_q[2:0] == 3'd1)); // R7
endmodule

// File: rtl/tk_date.sv
module tk_date
  import tk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  reg_t load_val_i,
  input  logic step_i,
  input  reg_t month_i,
  input  reg_t year_i,
  output reg_t date_o,
  output logic wrap_o
);
  reg_t date_q, date_d, lim;
  logic at_end, en;

  assign lim    = last_date(month_i, year_i);
  assign at_end = (date_q >= lim);
  assign wrap_o = step_i & at_end;
  assign en     = load_i | step_i;

  always_comb begin
    date_d = date_q;
    if (load_i)      date_d = load_val_i;
    else if (step_i) date_d = at_end ? 8'h01 : bcd_inc(date_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  date_q <= 8'h01;
    else if (en) date_q <= date_d;
  end

  assign date_o = date_q;

  AST_FEB_LEAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && month_i == 8'h02 && date_q == 8'h28 && year_i == 8'h24) |=> (date_q == 8'h29)); // R6

  AST_MONTH30_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && month_i == 8'h04 && date_q == 8'h30) |=> (date_q == 8'h01)); // R5
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [IMG_W-1:0] load_data_i,
  input  logic             ext_rst_n_i,
  output logic [IMG_W-1:0] regs_o,
  output logic             osc_off_o,
  output logic             rst_ignore_o,
  output logic             xfer_abort_o
);
  localparam int N_TIME = 3;

  logic [1:0] rsync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_int = rsync_q[1];

  logic [IMG_W-1:0] ld_img;
  assign ld_img = load_data_i & LIVE_MASK;

  reg_t day_r, hr_r, date_r, mon_r, yr_r;
  reg_t tval [N_TIME];
  logic [N_TIME:0] step;
  logic [N_TIME-1:0] twrap;
  logic day_step, date_wrap, mon_wrap, yr_wrap_unused;

  assign step[0] = tick_i & ~day_r[5];

  for (genvar g = 0; g < N_TIME; g++) begin : g_time
    localparam reg_t LIM = (g == 0) ? 8'h99 : 8'h59;
    tk_bcd_ring #(.LIMIT(LIM), .FIRST(8'h00), .RST_VAL(8'h00)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .load_i    (load_i),
      .load_val_i(ld_img[g*REG_W +: REG_W]),
      .step_i    (step[g]),
      .val_o     (tval[g]),
      .wrap_o    (twrap[g])
    );
    assign step[g+1] = twrap[g];
  end

  tk_hours u_hours (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_i    (load_i),
    .load_val_i(ld_img[3*REG_W +: REG_W]),
    .step_i    (step[N_TIME]),
    .hr_o      (hr_r),
    .day_step_o(day_step)
  );

  tk_weekday u_wday (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_i    (load_i),
    .load_val_i(ld_img[4*REG_W +: REG_W]),
    .step_i    (day_step),
    .day_o     (day_r)
  );

  tk_date u_date (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_i    (load_i),
    .load_val_i(ld_img[5*REG_W +: REG_W]),
    .step_i    (day_step),
    .month_i   (mon_r),
    .year_i    (yr_r),
    .date_o    (date_r),
    .wrap_o    (date_wrap)
  );

  tk_bcd_ring #(.LIMIT(8'h12), .FIRST(8'h01), .RST_VAL(8'h01)) u_month (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_i    (load_i),
    .load_val_i(ld_img[6*REG_W +: REG_W]),
    .step_i    (date_wrap),
    .val_o     (mon_r),
    .wrap_o    (mon_wrap)
  );

  tk_bcd_ring #(.LIMIT(8'h99), .FIRST(8'h00), .RST_VAL(8'h00)) u_year (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_i    (load_i),
    .load_val_i(ld_img[7*REG_W +: REG_W]),
    .step_i    (mon_wrap),
    .val_o     (yr_r),
    .wrap_o    (yr_wrap_unused)
  );

  assign regs_o       = {yr_r, mon_r, date_r, day_r, hr_r, tval[2], tval[1], tval[0]};
  assign osc_off_o    = day_r[5];
  assign rst_ignore_o = day_r[4];
  assign xfer_abort_o = ~day_r[4] & ~ext_rst_n_i;

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (osc_off_o && !load_i) |=> $stable(regs_o)); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n_int)
    load_i |=> (regs_o == ($past(load_data_i) & LIVE_MASK))); // R11

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((regs_o & ~LIVE_MASK) == '0)); // R10

  AST_ABORT_GATED: assert property (@(posedge clk) disable iff (!rst_n_int)
    rst_ignore_o |-> !xfer_abort_o); // R9

  AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n_int)
    (tick_i && !load_i && !osc_off_o) |=> (regs_o != $past(regs_o))); // R12

  AST_RESET_IMAGE: assert property (@(posedge clk)
    (!rst_n_int && !rsync_q[0]) |=> (regs_o == RST_IMAGE)); // R1
endmodule

// File: tb/sim_bcd_timekeeper.sv
module sim_bcd_timekeeper;
  localparam logic [63:0] MASK = 64'hFF1F_3F37_BF7F_7FFF;

  logic clk = 1'b0;
  logic rst_n, tick_i, load_i, ext_rst_n_i;
  logic [63:0] load_data_i, regs_o;
  logic osc_off_o, rst_ignore_o, xfer_abort_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_timekeeper u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int n);
    logic [7:0] r;
    r[7:4] = 4'(n / 10);
    r[3:0] = 4'(n % 10);
    return r;
  endfunction

  function automatic int mlen(input int mo, input int yr);
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    return 31;
  endfunction

  // independent model: binary arithmetic on decoded fields
  function automatic logic [63:0] mdl(input logic [63:0] s);
    int hu, se, mi, hr, h24, dw, dt, mo, yr;
    bit m12, newday;
    logic [7:0] dreg, hreg;
    dreg = s[39:32];
    if (dreg[5]) return s;
    hu = b2i(s[7:0]); se = b2i(s[15:8]); mi = b2i(s[23:16]);
    m12 = s[31];
    h24 = m12 ? (b2i({3'b0, s[28:24]}) % 12) + (s[29] ? 12 : 0) : b2i({2'b0, s[29:24]});
    dw = int'(dreg[2:0]); dt = b2i(s[47:40]); mo = b2i(s[55:48]); yr = b2i(s[63:56]);
    newday = 0;
    hu++;
    if (hu == 100) begin
      hu = 0; se++;
      if (se == 60) begin
        se = 0; mi++;
        if (mi == 60) begin
          mi = 0; h24++;
          if (h24 == 24) begin h24 = 0; newday = 1; end
        end
      end
    end
    if (newday) begin
      dw = (dw == 7) ? 1 : dw + 1;
      dt++;
      if (dt > mlen(mo, yr)) begin
        dt = 1; mo++;
        if (mo > 12) begin mo = 1; yr = (yr + 1) % 100; end
      end
    end
    if (m12) begin
      hr = h24 % 12;
      if (hr == 0) hr = 12;
      hreg = {1'b1, 1'b0, (h24 >= 12), i2b(hr)[4:0]};
    end else begin
      hreg = {2'b00, i2b(h24)[5:0]};
    end
    return {i2b(yr), i2b(mo), i2b(dt), dreg[7:3], 3'(dw), hreg, i2b(mi), i2b(se), i2b(hu)};
  endfunction

  function automatic logic [63:0] mk(input logic [7:0] yr, mo, dt, dy, hr, mi, se, hu);
    return {yr, mo, dt, dy, hr, mi, se, hu};
  endfunction

  // load state then apply n ticks; every cycle compared with the model
  task automatic run(input string req, input logic [63:0] st, input int n, input bit rnd);
    logic [63:0] exp;
    @(negedge clk);
    load_i = 1'b1; load_data_i = st; tick_i = 1'b0;
    @(negedge clk);
    load_i = 1'b0;
    exp = st & MASK;
    chk({req, " load"}, regs_o, exp);
    for (int i = 0; i < n; i++) begin
      tick_i = rnd ? ($urandom % 4 != 0) : 1'b1;
      if (tick_i) exp = mdl(exp);
      @(negedge clk);
      chk(req, regs_o, exp);
    end
    tick_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    int yr, mo, dt, hr, mi, se, hu, dw, seed;
    bit m12, pm;
    logic [7:0] hreg;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; tick_i = 1'b0; load_i = 1'b0; load_data_i = '0; ext_rst_n_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", regs_o, 64'h0001_0131_0000_0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", regs_o, 64'h0001_0131_0000_0000);
    chk("R1 ctrl bits", {62'd0, osc_off_o, rst_ignore_o}, 64'd3);

    // R8: stopped after reset, ticks ignored
    tick_i = 1'b1;
    repeat (5) @(negedge clk);
    tick_i = 1'b0;
    chk("R8 stopped", regs_o, 64'h0001_0131_0000_0000);

    // R9: abort gating
    ext_rst_n_i = 1'b0; #1;
    chk("R9 ignored", {63'd0, xfer_abort_o}, 64'd0);
    run("R9 load", mk(8'h10, 8'h05, 8'h05, 8'h02, 8'h10, 8'h00, 8'h00, 8'h00), 0, 0);
    #1 chk("R9 abort", {63'd0, xfer_abort_o}, 64'd1);
    ext_rst_n_i = 1'b1; #1;
    chk("R9 line high", {63'd0, xfer_abort_o}, 64'd0);

    // R12: one tick, one hundredth; idle holds
    @(negedge clk);
    chk("R12 idle", regs_o, mk(8'h10, 8'h05, 8'h05, 8'h02, 8'h10, 8'h00, 8'h00, 8'h00));
    tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    chk("R12 step", regs_o, mk(8'h10, 8'h05, 8'h05, 8'h02, 8'h10, 8'h00, 8'h00, 8'h01));

    // R10: unused bits cleared
    run("R10 zero bits", 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    chk("R10 image", regs_o, 64'hFF1F_3F37_BF7F_7FFF);

    // R11: load and tick together
    @(negedge clk);
    load_i = 1'b1; tick_i = 1'b1;
    load_data_i = mk(8'h42, 8'h07, 8'h14, 8'h43, 8'h05, 8'h30, 8'h20, 8'h99);
    @(negedge clk);
    load_i = 1'b0; tick_i = 1'b0;
    chk("R11 load wins", regs_o, mk(8'h42, 8'h07, 8'h14, 8'h03, 8'h05, 8'h30, 8'h20, 8'h99));

    // directed corners
    run("R2 sec carry", mk(8'h10, 8'h05, 8'h05, 8'h12, 8'h04, 8'h00, 8'h59, 8'h99), 3, 0);
    run("R2 min carry", mk(8'h10, 8'h05, 8'h05, 8'h12, 8'h04, 8'h59, 8'h59, 8'h99), 2, 0);
    run("R3 to 20", mk(8'h10, 8'h05, 8'h05, 8'h12, 8'h19, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R3 bit5", {56'd0, regs_o[31:24]}, 64'h20);
    run("R3 midnight", mk(8'h10, 8'h06, 8'h15, 8'h13, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R3 midnight", regs_o, mk(8'h10, 8'h06, 8'h16, 8'h14, 8'h00, 8'h00, 8'h00, 8'h00));
    run("R4 pm to am", mk(8'h10, 8'h06, 8'h15, 8'h13, 8'hB1, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R4 12am", {56'd0, regs_o[47:24]} >> 0, {40'd0, 8'h16, 8'h14, 8'h92});
    run("R4 am to pm", mk(8'h10, 8'h06, 8'h15, 8'h13, 8'h91, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R4 12pm", {56'd0, regs_o[31:24]}, 64'hB2);
    run("R4 12 to 1", mk(8'h10, 8'h06, 8'h15, 8'h13, 8'h92, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R4 1am", {56'd0, regs_o[31:24]}, 64'h81);
    run("R5 apr 30", mk(8'h10, 8'h04, 8'h30, 8'h11, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R5 may 1", {56'd0, regs_o[55:48]}, 64'h05);
    run("R5 jan 30", mk(8'h10, 8'h01, 8'h30, 8'h11, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    run("R5 jan 31", mk(8'h10, 8'h01, 8'h31, 8'h11, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    run("R6 feb 23", mk(8'h23, 8'h02, 8'h28, 8'h11, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R6 mar 1", {48'd0, regs_o[55:40]}, 64'h0301);
    run("R6 feb 24", mk(8'h24, 8'h02, 8'h28, 8'h11, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R6 feb 29", {48'd0, regs_o[55:40]}, 64'h0229);
    run("R6 feb 29 end", mk(8'h24, 8'h02, 8'h29, 8'h11, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    run("R6 year 00", mk(8'h00, 8'h02, 8'h28, 8'h11, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    run("R6 year 10", mk(8'h10, 8'h02, 8'h28, 8'h11, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    run("R7 new century", mk(8'h99, 8'h12, 8'h31, 8'h17, 8'h23, 8'h59, 8'h59, 8'h99), 1, 0);
    chk("R7 wrap", regs_o, mk(8'h00, 8'h01, 8'h01, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00));
    run("R8 stop bit", mk(8'h10, 8'h05, 8'h05, 8'h32, 8'h04, 8'h00, 8'h00, 8'h00), 4, 0);
    chk("R8 frozen", regs_o, mk(8'h10, 8'h05, 8'h05, 8'h32, 8'h04, 8'h00, 8'h00, 8'h00));

    // random states biased toward carries
    for (int k = 0; k < 60; k++) begin
      yr = $urandom % 100; mo = 1 + $urandom % 12;
      dt = ($urandom % 2) ? mlen(mo, yr) : 1 + $urandom % mlen(mo, yr);
      dw = 1 + $urandom % 7;
      m12 = $urandom % 2; pm = $urandom % 2;
      if (m12) begin
        hr = ($urandom % 2) ? 11 : 1 + $urandom % 12;
        hreg = {1'b1, 1'b0, pm, i2b(hr)[4:0]};
      end else begin
        hr = ($urandom % 2) ? 23 : $urandom % 24;
        hreg = {2'b00, i2b(hr)[5:0]};
      end
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      se = ($urandom % 2) ? 59 : $urandom % 60;
      hu = 80 + $urandom % 20;
      run((m12 ? "R4 random" : "R3 random"),
          mk(i2b(yr), i2b(mo), i2b(dt), {3'b000, 1'($urandom % 2), 1'b0, 3'(dw)},
             hreg, i2b(mi), i2b(se), i2b(hu)), 120, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule